// File: doc/BRIEF.md
# Programmable calibration test pulse generator

This block produces the timing pattern used to calibrate time-to-digital converter channels. A one-cycle start strobe opens a test cycle: the block raises a calibration-trigger marker at once, then drives a test pulse whose falling edge lands at a programmed tick, and closes the cycle with a common-stop pulse that begins at a second programmed tick. All times are counted in system-clock ticks from the accepted start strobe.

A two-bit mode selects whether the test pulse is suppressed, sent once, or sent twice. In the twice case a second pulse is added whose falling edge sits halfway between the first pulse's falling edge and the stop time, so downstream compaction logic sees two hits before the stop. If the programmed stop is not later than the pulse time while a pulse is requested, the cycle is refused and an error flag rises instead.

Top module: `cal_pulse_gen`

## Requirements
- R1: While reset is asserted, test_pulse_o, common_stop_o, cal_trig_o and err_o are all low.
- R2: After an accepted start, cal_trig_o is high for exactly TRIG_W ticks, at ticks 0 to TRIG_W-1, where tick 0 is the first cycle after the clock edge that samples start_i high.
- R3: With mode_i = 2'b01 (single), test_pulse_o is high exactly at the ticks n with n < T and n + PULSE_W >= T, where T is pulse_time_i; it therefore falls at tick T and is PULSE_W ticks wide when T >= PULSE_W.
- R4: common_stop_o is high exactly at ticks S to S+PULSE_W-1, where S is stop_time_i, in every mode.
- R5: With mode_i = 2'b10 (double), test_pulse_o is the union of the R3 window for T and the same kind of window ending at M = (T + S) >> 1, the sum taken without overflow.
- R6: With mode_i = 2'b00 or 2'b11 (off), test_pulse_o stays low for the whole cycle while cal_trig_o and common_stop_o behave as in R2 and R4, and no error is raised whatever T and S are.
- R7: With mode single or double and S <= T, the start is refused: err_o is high from tick 0, no output pulse follows, and err_o stays high until the next accepted start with valid settings, at whose tick 0 it is low.
- R8: A start strobe, and any change of mode_i, pulse_time_i or stop_time_i, while a cycle is running has no effect on that cycle, including at its final tick.
- R9: The cycle ends after tick max(S+PULSE_W, TRIG_W)-1; all outputs are then low, and a start sampled in the first cycle after that last tick is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Test-cycle start strobe |
| mode_i | input | 2 | 00/11 off, 01 single pulse, 10 double pulse |
| pulse_time_i | input | TIME_W (20) | Tick of the first test pulse's falling edge |
| stop_time_i | input | TIME_W (20) | Tick at which the common stop begins |
| test_pulse_o | output | 1 | Test pulse line |
| common_stop_o | output | 1 | Common-stop line |
| cal_trig_o | output | 1 | Calibration-trigger marker |
| err_o | output | 1 | Refused-cycle flag (stop not after pulse) |

## Verification
Directed cycles place the pulse time below the pulse width (clipped window), make the midpoint window overlap the first one, use an odd time sum (rounding of the midpoint) and set the stop at tick 0 in off mode (stop under the marker), which separates errors in each window bound. Refused cycles with equal and reversed times tell the strict comparison from a lax one, and a following valid cycle shows the flag clearing. Strobes and new settings injected mid-cycle and at the final tick, then a start right after the last tick, separate a correctly ignored start from an early or late cycle end. Random times and modes then compare every output tick against a bench model.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    // Test pulse mode; both 00 and 11 suppress the pulse.
    typedef enum logic [1:0] {
        TPM_OFF    = 2'b00,
        TPM_SINGLE = 2'b01,
        TPM_DOUBLE = 2'b10,
        TPM_OFF_B  = 2'b11
    } tp_mode_e;

endpackage

// File: rtl/cpg_midpoint.sv
// Halfway point of two times, rounded down, computed with a carry bit.
module cpg_midpoint #(
    parameter int W = 20
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mid_o
);
    logic [W:0] sum;

    always_comb begin
        sum   = {1'b0, a_i} + {1'b0, b_i};
        mid_o = sum[W:1];
    end
endmodule

// File: rtl/cpg_window.sv
// High for LEN ticks ending just before edge_i (clipped at tick 0).
module cpg_window #(
    parameter int CW  = 21,
    parameter int LEN = 5
) (
    input  logic [CW-1:0] now_i,
    input  logic [CW-1:0] edge_i,
    output logic          hit_o
);
    logic [CW:0] reach;

    always_comb begin
        reach = {1'b0, now_i} + (CW+1)'(LEN);
        hit_o = (now_i < edge_i) && (reach >= {1'b0, edge_i});
    end
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
    import cpg_pkg::*;
#(
    parameter int TIME_W  = 20,
    parameter int PULSE_W = 5,
    parameter int TRIG_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [TIME_W-1:0] pulse_time_i,
    input  logic [TIME_W-1:0] stop_time_i,
    output logic              test_pulse_o,
    output logic              common_stop_o,
    output logic              cal_trig_o,
    output logic              err_o
);
    localparam int CW = TIME_W + 1;   // tick counter covers stop + width
    localparam int NW = 3;            // windows: pulse 1, pulse 2, stop

    typedef struct packed {
        logic              active;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     last;
        logic [TIME_W-1:0] t1;
        logic [TIME_W-1:0] ts;
        logic              en;
        logic              dbl;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    // ---------------- window decode on latched settings ----------------
    logic [TIME_W-1:0] mid;
    logic [CW-1:0]     edge_v [NW];
    logic [NW-1:0]     hit;

    cpg_midpoint #(.W(TIME_W)) u_mid (
        .a_i   (st_q.t1),
        .b_i   (st_q.ts),
        .mid_o (mid)
    );

    always_comb begin
        edge_v[0] = {1'b0, st_q.t1};
        edge_v[1] = {1'b0, mid};
        edge_v[2] = {1'b0, st_q.ts} + CW'(PULSE_W);
    end

    generate
        for (genvar w = 0; w < NW; w++) begin : g_win
            cpg_window #(.CW(CW), .LEN(PULSE_W)) u_win (
                .now_i  (st_q.cnt),
                .edge_i (edge_v[w]),
                .hit_o  (hit[w])
            );
        end
    endgenerate

    // ---------------- next state ----------------
    tp_mode_e   mode_in;
    logic       new_en, new_bad, accept;
    logic [CW-1:0] stop_end, span;

    always_comb begin
        mode_in  = tp_mode_e'(mode_i);
        new_en   = (mode_in == TPM_SINGLE) || (mode_in == TPM_DOUBLE);
        new_bad  = new_en && (stop_time_i <= pulse_time_i);
        accept   = start_i && !st_q.active;
        stop_end = {1'b0, stop_time_i} + CW'(PULSE_W);
        span     = (stop_end > CW'(TRIG_W)) ? stop_end : CW'(TRIG_W);

        st_d = st_q;
        if (accept) begin
            st_d.t1     = pulse_time_i;
            st_d.ts     = stop_time_i;
            st_d.en     = new_en;
            st_d.dbl    = (mode_in == TPM_DOUBLE);
            st_d.cnt    = '0;
            st_d.last   = span - CW'(1);
            st_d.err    = new_bad;
            st_d.active = !new_bad;
        end else if (st_q.active) begin
            if (st_q.cnt == st_q.last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cal_trig_o    = st_q.active && (st_q.cnt < CW'(TRIG_W));
        common_stop_o = st_q.active && hit[2];
        test_pulse_o  = st_q.active && st_q.en && (hit[0] || (st_q.dbl && hit[1]));
        err_o         = st_q.err;
    end

    // ---------------- assertions ----------------
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !(test_pulse_o || common_stop_o || cal_trig_o || err_o));

    p_trig_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.active && !new_bad) |=> cal_trig_o);

    p_err_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(test_pulse_o || common_stop_o || cal_trig_o));

    p_pulse_needs_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        test_pulse_o |-> st_q.en);

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && start_i) |=> $stable(st_q.ts) && $stable(st_q.t1) && !err_o);

    generate
        if (PULSE_W >= 2) begin : g_width_chk
            p_stop_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(common_stop_o) |=> common_stop_o);
        end
    endgenerate

endmodule

// File: tb/cal_pulse_gen_bench.sv
module cal_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TIME_W     = 20;
    localparam int PULSE_W    = 5;
    localparam int TRIG_W     = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [TIME_W-1:0] pulse_time_i = '0;
    logic [TIME_W-1:0] stop_time_i = '0;
    logic test_pulse_o, common_stop_o, cal_trig_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_pulse_gen #(.TIME_W(TIME_W), .PULSE_W(PULSE_W), .TRIG_W(TRIG_W)) u_cal_pulse_gen (
        .clk, .rst_n, .start_i, .mode_i, .pulse_time_i, .stop_time_i,
        .test_pulse_o, .common_stop_o, .cal_trig_o, .err_o
    );

    function automatic bit win(int n, int e);
        return (n < e) && (n + PULSE_W >= e);
    endfunction

    function automatic bit exp_tp(int md, int t1, int ts, int n);
        if (md == 1) return win(n, t1);
        if (md == 2) return win(n, t1) || win(n, (t1 + ts) >> 1);
        return 1'b0;
    endfunction

    function automatic int last_tick(int ts);
        return ((ts + PULSE_W > TRIG_W) ? ts + PULSE_W : TRIG_W) - 1;
    endfunction

    task automatic check(bit got, bit exp, string req, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_idle(string req);
        check(test_pulse_o,  1'b0, req, "idle test_pulse");
        check(common_stop_o, 1'b0, req, "idle common_stop");
        check(cal_trig_o,    1'b0, req, "idle cal_trig");
    endtask

    // Called at a negedge; returns at the negedge after the cycle's last tick.
    task automatic run(int md, int t1, int ts, bit inject);
        bit en, bad;
        int last;
        string tp_req;
        en  = (md == 1) || (md == 2);
        bad = en && (ts <= t1);
        mode_i = 2'(md); pulse_time_i = TIME_W'(t1); stop_time_i = TIME_W'(ts);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (bad) begin
            for (int k = 0; k < 4; k++) begin
                check(err_o, 1'b1, "R7", "err on refused cycle");
                check_idle("R7");
                @(negedge clk);
            end
            return;
        end
        last   = last_tick(ts);
        tp_req = (md == 2) ? "R5" : (en ? "R3" : "R6");
        for (int n = 0; n <= last; n++) begin
            check(err_o, 1'b0, "R7", "err clear on valid cycle");
            check(cal_trig_o, (n < TRIG_W), (n == 0) ? "R2 R9" : "R2", "cal_trig");
            check(common_stop_o, (n >= ts) && (n < ts + PULSE_W), "R4", "common_stop");
            check(test_pulse_o, exp_tp(md, t1, ts, n), tp_req, "test_pulse");
            if (inject && (n == 3 || n == last)) begin
                start_i = 1'b1;
                mode_i = 2'(($urandom % 4));
                pulse_time_i = TIME_W'($urandom % 50);
                stop_time_i = TIME_W'($urandom % 50);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check_idle(inject ? "R8" : "R9");
    endtask

    initial begin
        void'($urandom(32'd1810));
        @(negedge clk);
        check_idle("R1");
        check(err_o, 1'b0, "R1", "err in reset");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        run(1, 10, 30, 1'b0);   // single
        run(2, 10, 40, 1'b0);   // double, midpoint 25
        run(1, 2, 20, 1'b0);    // pulse time under width: clipped
        run(0, 0, 0, 1'b0);     // off, stop under marker
        run(3, 50, 15, 1'b0);   // off alternate code, reversed times allowed
        run(2, 10, 12, 1'b0);   // overlapping windows
        run(2, 7, 20, 1'b0);    // odd sum, midpoint 13
        run(1, 20, 20, 1'b0);   // refused: equal
        run(2, 30, 5, 1'b0);    // refused: reversed
        run(0, 50, 10, 1'b0);   // valid cycle clears err
        run(1, 8, 25, 1'b1);    // strobes injected mid-cycle and at last tick
        run(2, 4, 9, 1'b1);

        for (int i = 0; i < 40; i++) begin
            run(int'($urandom % 4), int'($urandom % 60), int'($urandom % 80), ($urandom % 3) == 0);
            if (($urandom % 2) == 1) @(negedge clk);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule